// File: doc/BRIEF.md
# Pipelined (15,5) BCH Majority-Logic Decoder

This block takes one 15-bit codeword of the binary (15,5) BCH code on every clock. It returns the five message bits, with up to three bit errors in the received word repaired. The bit-serial cyclic decoding loop is laid out as a chain of fifteen identical stages. Each stage judges the bit that currently sits in the top position and inverts it if the vote says it is wrong. It then rotates the word one place, so the next stage faces the next bit. After fifteen rotations the word is back in its original alignment, and the message field is taken from it.

Each stage decides in two steps. The first step forms six first-level estimates, each a six-input majority. Each estimate judges whether the bit under test and one partner bit are in error together. The partner bit is different for each estimate. Each of the six check sums behind an estimate is the XOR of four received bits. Those four bits form an affine plane of the field that leaves out the zero point, so the XOR can be built with two levels of gates. The second step takes a majority over the six estimates, and that result decides whether the bit is flipped.

The parameter `STAGE_SPLIT` sets the pipeline depth. With it cleared, each stage has one register level and the latency is 15 clocks. With it set, a register is placed between the two voting steps and the latency is 30 clocks. The chain never stalls, and a qualifying valid bit moves along with each word.

Top module: `bch15_ml_decoder`

## Requirements
- R1: The code is systematic with generator polynomial 0x537 (x^10+x^8+x^5+x^4+x^2+x+1). The message occupies word bits [14:10], with the most significant message bit in bit 14, and the remainder of the message times x^10 fills bits [9:0]. An error-free codeword of this form yields its message on `out_data`.
- R2: Every one of the 32 codewords, received without error, yields its own message.
- R3: Every single-bit error, in any of the 15 positions of any codeword, is corrected.
- R4: Every two-bit error pattern in any codeword is corrected.
- R5: Every three-bit error pattern in any codeword is corrected, including patterns that lie wholly in the message field.
- R6: A word presented with `in_valid` high leaves with `out_valid` high exactly 15 clocks later when `STAGE_SPLIT`=0, and 30 clocks later when it is 1. A new word may enter on every clock.
- R7: Words on consecutive clocks decode independently. A heavily corrupted word does not alter the result for its neighbour.
- R8: `out_valid` is low during reset and stays low until a valid word has crossed the whole pipeline. A clock with `in_valid` low never produces a valid output, whatever `in_word` holds.
- R9: A reset applied while words are in flight discards them all. None of them appears at the output after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid chain |
| in_valid | input | 1 | Qualifies `in_word` for this clock |
| in_word | input | 15 | Received codeword, message in bits [14:10] |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | 5 | Corrected message bits |

## Verification
A correction decision in one stage and a fresh word entering the first stage fall in the same clock whenever words arrive back to back. The two must not interact: the word that enters cannot be affected by the corrections being made on the words ahead of it. The exhaustive sweep provokes this by streaming every codeword with every error pattern of weight zero to three on consecutive clocks, so that fifteen corrections are in progress at once. A directed run of badly damaged words next to clean ones provokes it further. The bench judges each output against its own encoder, in arrival order and at the exact latency. It also checks that bubbles and a mid-stream reset leave no valid output behind.

// File: rtl/bchml_pkg.sv
package bchml_pkg;

  localparam int CW_N    = 15;
  localparam int CW_K    = 5;
  localparam int CW_R    = CW_N - CW_K;
  localparam int GF_M    = 4;
  localparam logic [CW_R:0] GEN_POLY = 11'h537;
  localparam logic [GF_M-1:0] PRIM_TAIL = 4'b0011;
  localparam int TGT     = CW_N - 1;
  localparam int N_PART  = 6;
  localparam int N_CHK   = 6;
  localparam int MAJ_W   = 6;
  localparam int MAJ_TH  = MAJ_W / 2 + 1;

  typedef logic [CW_N-1:0]   cw_t;
  typedef logic [CW_K-1:0]   msg_t;
  typedef logic [N_PART-1:0] est_t;

  function automatic logic [GF_M-1:0] gf_pow(input int e);
    logic [GF_M-1:0] v;
    v = 4'b0001;
    for (int i = 0; i < e; i++)
      v = {v[GF_M-2:0], 1'b0} ^ (v[GF_M-1] ? PRIM_TAIL : 4'b0000);
    return v;
  endfunction

  function automatic int gf_log(input logic [GF_M-1:0] v);
    for (int i = 0; i < CW_N; i++)
      if (gf_pow(i) == v) return i;
    return 0;
  endfunction

  function automatic int plane_pos(input int k, input int j, input bit side);
    logic [GF_M-1:0] p, q, d, rv, sv;
    int cnt;
    p = gf_pow(TGT);
    q = gf_pow(k);
    d = p ^ q;
    cnt = 0;
    for (int r = 1; r < (1 << GF_M); r++) begin
      rv = GF_M'(r);
      sv = rv ^ d;
      if (rv == p || rv == q || rv == d || rv > sv) continue;
      if (cnt == j) return gf_log(side ? sv : rv);
      cnt++;
    end
    return 0;
  endfunction

  function automatic logic maj_vote(input logic [MAJ_W-1:0] x);
    return $countones(x) >= MAJ_TH;
  endfunction

  function automatic cw_t rot1(input cw_t w);
    return {w[CW_N-2:0], w[CW_N-1]};
  endfunction

  function automatic logic [CW_R-1:0] poly_rem(input cw_t w);
    cw_t r;
    r = w;
    for (int i = CW_N - 1; i >= CW_R; i--)
      if (r[i]) r = r ^ (cw_t'(GEN_POLY) << (i - CW_R));
    return r[CW_R-1:0];
  endfunction

endpackage

// File: rtl/bchml_estimates.sv
module bchml_estimates
  import bchml_pkg::*;
(
  input  cw_t  word,
  output est_t est
);

  logic [N_PART-1:0][N_CHK-1:0] chk;

  for (genvar k = 0; k < N_PART; k++) begin : g_part
    for (genvar j = 0; j < N_CHK; j++) begin : g_plane
      localparam int PA = plane_pos(k, j, 1'b0);
      localparam int PB = plane_pos(k, j, 1'b1);
      assign chk[k][j] = (word[TGT] ^ word[k]) ^ (word[PA] ^ word[PB]);
    end
    assign est[k] = maj_vote(chk[k]);
  end

endmodule

// File: rtl/bchml_stage.sv
module bchml_stage
  import bchml_pkg::*;
#(
  parameter bit SPLIT = 1'b0
)(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  cw_t  in_word,
  output logic out_valid,
  output cw_t  out_word
);

  est_t est;
  logic flip;
  logic fwd_valid;
  cw_t  fixed;

  bchml_estimates u_est (
    .word (in_word),
    .est  (est)
  );

  if (SPLIT) begin : g_split
    logic mid_valid;
    cw_t  mid_word;
    est_t mid_est;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mid_valid <= 1'b0;
      else        mid_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
      mid_word <= in_word;
      mid_est  <= est;
    end

    assign flip      = maj_vote(mid_est);
    assign fixed     = mid_word ^ (cw_t'(flip) << TGT);
    assign fwd_valid = mid_valid;
  end else begin : g_flat
    assign flip      = maj_vote(est);
    assign fixed     = in_word ^ (cw_t'(flip) << TGT);
    assign fwd_valid = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= fwd_valid;
  end

  always_ff @(posedge clk) begin
    out_word <= rot1(fixed);
  end

endmodule

// File: rtl/bch15_ml_decoder.sv
module bch15_ml_decoder
  import bchml_pkg::*;
#(
  parameter bit STAGE_SPLIT = 1'b0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CW_N-1:0]  in_word,
  output logic             out_valid,
  output logic [CW_K-1:0]  out_data
);

  localparam int LATENCY = CW_N * (STAGE_SPLIT ? 2 : 1);

  logic stv [CW_N+1];
  cw_t  stw [CW_N+1];

  assign stv[0] = in_valid;
  assign stw[0] = in_word;

  for (genvar s = 0; s < CW_N; s++) begin : g_stage
    bchml_stage #(.SPLIT(STAGE_SPLIT)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (stv[s]),
      .in_word   (stw[s]),
      .out_valid (stv[s+1]),
      .out_word  (stw[s+1])
    );
  end

  assign out_valid = stv[CW_N];
  assign out_data  = stw[CW_N][CW_N-1 -: CW_K];

endmodule

// File: rtl/bchml_checker.sv
module bchml_checker
  import bchml_pkg::*;
#(
  parameter bit STAGE_SPLIT = 1'b0
)(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [CW_N-1:0] in_word,
  input logic            out_valid,
  input logic [CW_K-1:0] out_data
);

  localparam int LAT = CW_N * (STAGE_SPLIT ? 2 : 1);
  localparam int FW  = $clog2(LAT + 1);

  logic [FW-1:0] fill;
  logic          clean_in;

  assign clean_in = in_valid && (poly_rem(in_word) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fill <= '0;
    else if (fill != FW'(LAT)) fill <= fill + 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FW'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R6

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != FW'(LAT)) |-> !out_valid); // R8

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FW'(LAT) && $past(clean_in, LAT)) |-> (out_data == $past(in_word[CW_N-1 -: CW_K], LAT))); // R2

  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R9

endmodule

bind bch15_ml_decoder bchml_checker #(.STAGE_SPLIT(STAGE_SPLIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/bch15_ml_decoder_bench.sv
module bch15_ml_decoder_bench;

  localparam bit SPLIT = 1'b0;
  localparam int LAT   = SPLIT ? 30 : 15;
  localparam logic [10:0] GEN = 11'h537;

  typedef struct {
    logic [4:0] d;
    int         cyc;
    int         req;
  } exp_t;

  // {received word, expected message, requirement}
  localparam logic [24:0] VEC [16] = '{
    {15'h0537, 5'h01, 5'd1},   // R1 data 1 is the generator itself
    {15'h429B, 5'h10, 5'd1},   // R1
    {15'h7FFF, 5'h1F, 5'd1},   // R1 all-ones word
    {15'h0000, 5'h00, 5'd1},   // R1
    {15'h0A6E, 5'h02, 5'd1},   // R1
    {15'h0536, 5'h01, 5'd3},   // R3 parity bit 0 hit
    {15'h3FFF, 5'h1F, 5'd3},   // R3 top bit hit
    {15'h029A, 5'h10, 5'd4},   // R4
    {15'h066E, 5'h02, 5'd4},   // R4 two message bits hit
    {15'h0FFF, 5'h1F, 5'd5},   // R5 three message bits hit
    {15'h0700, 5'h00, 5'd5},   // R5
    {15'h4201, 5'h00, 5'd5},   // R5 spread pattern
    {15'h0FFF, 5'h1F, 5'd7},   // R7 damaged word then clean neighbour
    {15'h0000, 5'h00, 5'd7},   // R7
    {15'h7EEE, 5'h1F, 5'd7},   // R7
    {15'h0537, 5'h01, 5'd7}    // R7
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [14:0] in_word = '0;
  logic       out_valid;
  logic [4:0] out_data;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  bch15_ml_decoder #(.STAGE_SPLIT(SPLIT)) u_bch15_ml_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [14:0] encode(input logic [4:0] d);
    logic [9:0] p;
    logic       fb;
    p = '0;
    for (int i = 4; i >= 0; i--) begin
      fb = d[i] ^ p[9];
      p  = {p[8:0], 1'b0};
      if (fb) p = p ^ GEN[9:0];
    end
    return {d, p};
  endfunction

  always @(negedge clk) begin
    bit exp_v;
    exp_v = rst_n && q.size() > 0 && (q[0].cyc + LAT == cyc);
    n_chk++;
    if (out_valid !== exp_v) begin
      n_err++;
      $display("FAIL %s: out_valid=%0b expected %0b at cycle %0d",
               exp_v ? "R6" : "R8", out_valid, exp_v, cyc);
    end
    if (exp_v && out_valid === 1'b1) begin
      n_chk++;
      if (out_data !== q[0].d) begin
        n_err++;
        $display("FAIL R%0d: out_data=%h expected %h", q[0].req, out_data, q[0].d);
      end
    end
    if (q.size() > 0 && q[0].cyc + LAT <= cyc) void'(q.pop_front());
  end

  task automatic send(input logic [14:0] w, input logic [4:0] d, input int req);
    @(negedge clk); #1;
    in_valid = 1'b1;
    in_word  = w;
    q.push_back('{d: d, cyc: cyc, req: req});
  endtask

  task automatic idle(input int n, input logic [14:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b0;
      in_word  = junk ^ 15'(i * 7);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R8 reset state, with junk on the input
    in_word = 15'h5A5A;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1 in_valid = 1'b0;
    rst_n = 1'b1;
    idle(LAT + 2, 15'h1234);

    // directed table, back to back (R1, R3, R4, R5, R7)
    for (int i = 0; i < 16; i++)
      send(VEC[i][24:10], VEC[i][9:5], int'(VEC[i][4:0]));
    idle(LAT + 2, 15'h7FFF);

    // exhaustive sweep, one word per clock: R2 R3 R4 R5 R6 R7
    for (int d = 0; d < 32; d++) begin
      logic [14:0] c;
      c = encode(5'(d));
      send(c, 5'(d), 2);
      for (int a = 0; a < 15; a++) send(c ^ (15'd1 << a), 5'(d), 3);
      for (int a = 0; a < 15; a++)
        for (int b = a + 1; b < 15; b++)
          send(c ^ (15'd1 << a) ^ (15'd1 << b), 5'(d), 4);
      for (int a = 0; a < 15; a++)
        for (int b = a + 1; b < 15; b++)
          for (int e = b + 1; e < 15; e++)
            send(c ^ (15'd1 << a) ^ (15'd1 << b) ^ (15'd1 << e), 5'(d), 5);
    end
    idle(LAT + 2, 15'h0F0F);

    // R8 bubbles with junk words between valid ones
    for (int i = 0; i < 20; i++) begin
      send(encode(5'(i)) ^ 15'h0100, 5'(i), 3);
      idle(2, 15'h6B3C ^ 15'(i));
    end
    idle(LAT + 2, 15'h2222);

    // R9 reset while words are in flight
    for (int i = 0; i < 10; i++) send(encode(5'(i + 3)), 5'(i + 3), 9);
    @(negedge clk); #1;
    rst_n = 1'b0;
    in_valid = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(LAT + 4, 15'h3C3C);
    for (int i = 0; i < 4; i++) send(encode(5'(i + 20)) ^ 15'h4001, 5'(i + 20), 9);
    idle(LAT + 2, 15'h0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule